// File: doc/BRIEF.md
# Per-Instruction Way-Demand Predictor

This block keeps, for each memory instruction, a prediction of how many ways of a cache set that instruction needs to serve all of its reuses. Instructions are identified by a 15-bit partial program counter. The table is set-associative. The low bits of the partial PC choose a set, and the upper bits are stored as a tag. A cache replacement engine asks the table whether an instruction has finished learning and how many ways it should hold. It then tells the table about hits, which carry a hit position, and about evictions, which carry the per-line maximal hit position (MHP). A hit in a shadow tag is reported the same way as a cache hit. The caller computes that hit position as if the shadow entry sat at its life position.

Prediction grows at once: a hit whose position is above the stored count raises the count to that position and fills the confidence counter. Prediction shrinks slowly: an eviction whose MHP is below the count first drains the confidence counter, and only lowers the count once the counter is empty. On every hit and eviction the block also returns the MHP value that the caller must write back into the line's metadata.

Requests are handled by a two-state controller. In `ST_IDLE` the block is ready, and a valid request moves it to `ST_EXEC` (transition "accept"). In `ST_EXEC` the table is read, updated and answered, and the controller always returns to `ST_IDLE` (transition "complete"). Operation codes on `req_op` are: 0 lookup, 1 allocate, 2 hit, 3 evict.

Top module: `wbp_table`

## Requirements
- R1: After reset, every entry is invalid, `req_ready` is 1 and `rsp_valid` is 0. A lookup then reports found 0, learned 0 and count equal to ASSOC (16 by default).
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the following cycle. `rsp_valid` is a one-cycle pulse registered on the next rising edge after the accepting edge.
- R3: Allocate (op 1) of an absent PC creates an entry with learned 0, count ASSOC and confidence 0, and reports found 1. Allocate of a present PC leaves the entry unchanged and reports its current fields. A PC is never held twice.
- R4: A hit (op 2) is applied only when hit position ≥ supplied MHP. In that case `rsp_mhp_wr` is 1 and `rsp_mhp` is the hit position. Otherwise `rsp_mhp_wr` is 0 and the entry is unchanged.
- R5: An applied hit whose position exceeds the stored count sets the count to the hit position and the confidence to 3. A position at or below the count changes nothing.
- R6: Evict (op 3) of a present PC sets learned to 1. Every evict reports `rsp_mhp_wr` 1 with `rsp_mhp` 0, the start value for the newly inserted line.
- R7: Evict with MHP below the count decrements a non-zero confidence. With confidence 0, it decrements the count instead. An MHP at or above the count changes nothing. The count never goes below 0 or above ASSOC.
- R8: Lookup, hit or evict of an absent PC creates no entry and reports found 0, learned 0 and count ASSOC. The hit gate and the evict MHP output still apply.
- R9: Each table set holds 4 ways. An allocate fills an invalid way first, otherwise it replaces the least recently used way. Every operation on a present PC marks its way most recently used.
- R10: The set index is `req_pc[6:0]` and the tag is `req_pc[14:7]`. PCs with the same index and different tags are distinct entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 lookup, 1 allocate, 2 hit, 3 evict |
| req_pc | input | 15 | Partial PC of the instruction |
| req_hitpos | input | 5 | Hit position (hit only) |
| req_mhp | input | 5 | Line's stored MHP (hit and evict) |
| rsp_valid | output | 1 | Response pulse |
| rsp_found | output | 1 | Entry present after the operation |
| rsp_learned | output | 1 | Learned flag after the operation |
| rsp_wblocks | output | 5 | Predicted way count after the operation |
| rsp_mhp_wr | output | 1 | Caller must write `rsp_mhp` into the line |
| rsp_mhp | output | 5 | New MHP value for the line |

## Verification
Every result is due in the cycle that follows the one in which the request is taken. The driver therefore stamps each expected response with the cycle count two rising edges after it presents the request. The monitor compares the response on the falling edge of exactly that cycle, and reports a missing or an unexpected pulse as a miscompare. The driver also checks that `req_ready` is low in the cycle right after acceptance. Confidence is not visible at the ports, so its value is shown through the number of evictions needed before the count moves.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_ALLOC  = 2'd1,
        OP_HIT    = 2'd2,
        OP_EVICT  = 2'd3
    } wbp_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_EXEC
    } wbp_state_e;

    localparam logic [1:0] CONF_FULL = 2'd3;
endpackage

// File: rtl/wbp_tag_match.sv
module wbp_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        chk_en,
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        match,
    output logic [WAY_W-1:0]            match_way
);
    logic [WAYS-1:0] match_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_vec[g] = way_valid[g] && (way_tag[g] == probe_tag);
    end

    always_comb begin
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) match_way = WAY_W'(w);
        end
    end

    assign match = |match_vec;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> $onehot0(match_vec)); // R3
endmodule

// File: rtl/wbp_lru.sv
module wbp_lru #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    input  logic [WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  oldest_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_old
        assign oldest_vec[g] = (age_q[rd_set][g] == WAY_W'(WAYS - 1));
    end

    always_comb begin
        victim_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (oldest_vec[w]) victim_way = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) victim_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[rd_set][w] <= '0;
                end else if (age_q[rd_set][w] < age_q[rd_set][touch_way]) begin
                    age_q[rd_set][w] <= age_q[rd_set][w] + 1'b1;
                end
            end
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec)); // R9
endmodule

// File: rtl/wbp_update.sv
module wbp_update
    import wbp_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ASSOC = 16
) (
    input  wbp_op_e          op,
    input  logic             found,
    input  logic             cur_learned,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic [1:0]       cur_conf,
    input  logic [CNT_W-1:0] hitpos,
    input  logic [CNT_W-1:0] line_mhp,
    output logic             ent_we,
    output logic             nxt_learned,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic [1:0]       nxt_conf,
    output logic             rep_found,
    output logic             rep_learned,
    output logic [CNT_W-1:0] rep_cnt,
    output logic             mhp_wr,
    output logic [CNT_W-1:0] mhp_new
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ASSOC);

    always_comb begin
        ent_we      = 1'b0;
        nxt_learned = cur_learned;
        nxt_cnt     = cur_cnt;
        nxt_conf    = cur_conf;
        mhp_wr      = 1'b0;
        mhp_new     = '0;
        unique case (op)
            OP_LOOKUP: begin
            end
            OP_ALLOC: begin
                if (!found) begin
                    ent_we      = 1'b1;
                    nxt_learned = 1'b0;
                    nxt_cnt     = FULL_CNT;
                    nxt_conf    = '0;
                end
            end
            OP_HIT: begin
                if (hitpos >= line_mhp) begin
                    mhp_wr  = 1'b1;
                    mhp_new = hitpos;
                    if (found && (hitpos > cur_cnt)) begin
                        ent_we   = 1'b1;
                        nxt_cnt  = hitpos;
                        nxt_conf = CONF_FULL;
                    end
                end
            end
            OP_EVICT: begin
                mhp_wr  = 1'b1;
                mhp_new = '0;
                if (found) begin
                    ent_we      = 1'b1;
                    nxt_learned = 1'b1;
                    if (line_mhp < cur_cnt) begin
                        if (cur_conf != 2'd0) nxt_conf = cur_conf - 1'b1;
                        else                  nxt_cnt  = cur_cnt - 1'b1;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    assign rep_found   = found || (op == OP_ALLOC);
    assign rep_learned = rep_found ? nxt_learned : 1'b0;
    assign rep_cnt     = rep_found ? nxt_cnt : FULL_CNT;
endmodule

// File: rtl/wbp_table.sv
module wbp_table
    import wbp_pkg::*;
#(
    parameter int PC_W    = 15,
    parameter int ENTRIES = 512,
    parameter int WAYS    = 4,
    parameter int ASSOC   = 16,
    localparam int SETS   = ENTRIES / WAYS,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = PC_W - IDX_W,
    localparam int CNT_W  = $clog2(ASSOC) + 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [PC_W-1:0]  req_pc,
    input  logic [CNT_W-1:0] req_hitpos,
    input  logic [CNT_W-1:0] req_mhp,
    output logic             rsp_valid,
    output logic             rsp_found,
    output logic             rsp_learned,
    output logic [CNT_W-1:0] rsp_wblocks,
    output logic             rsp_mhp_wr,
    output logic [CNT_W-1:0] rsp_mhp
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ASSOC);

    wbp_state_e state_q, state_d;

    wbp_op_e          op_q;
    logic [PC_W-1:0]  pc_q;
    logic [CNT_W-1:0] hitpos_q;
    logic [CNT_W-1:0] mhp_q;

    logic             v_q       [SETS][WAYS];
    logic [TAG_W-1:0] tag_q     [SETS][WAYS];
    logic             learned_q [SETS][WAYS];
    logic [CNT_W-1:0] cnt_q     [SETS][WAYS];
    logic [1:0]       conf_q    [SETS][WAYS];

    logic [IDX_W-1:0]             set_sel;
    logic [TAG_W-1:0]             tag_sel;
    logic [WAYS-1:0]              row_valid;
    logic [WAYS-1:0][TAG_W-1:0]   row_tag;
    logic                         found;
    logic [WAY_W-1:0]             found_way;
    logic [WAY_W-1:0]             victim_way;
    logic [WAY_W-1:0]             tgt_way;
    logic                         in_exec;

    logic             ent_we, nxt_learned, rep_found, rep_learned, upd_mhp_wr;
    logic [CNT_W-1:0] nxt_cnt, rep_cnt, upd_mhp;
    logic [1:0]       nxt_conf;

    assign in_exec   = (state_q == ST_EXEC);
    assign req_ready = (state_q == ST_IDLE);
    assign set_sel   = pc_q[IDX_W-1:0];
    assign tag_sel   = pc_q[PC_W-1:IDX_W];
    assign tgt_way   = found ? found_way : victim_way;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_LOOKUP;
            pc_q     <= '0;
            hitpos_q <= '0;
            mhp_q    <= '0;
        end else if (req_ready && req_valid) begin
            op_q     <= wbp_op_e'(req_op);
            pc_q     <= req_pc;
            hitpos_q <= req_hitpos;
            mhp_q    <= req_mhp;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_valid[w] = v_q[set_sel][w];
            row_tag[w]   = tag_q[set_sel][w];
        end
    end

    wbp_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_en    (in_exec),
        .way_valid (row_valid),
        .way_tag   (row_tag),
        .probe_tag (tag_sel),
        .match     (found),
        .match_way (found_way)
    );

    wbp_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (set_sel),
        .way_valid  (row_valid),
        .victim_way (victim_way),
        .touch_en   (in_exec && (found || op_q == OP_ALLOC)),
        .touch_way  (tgt_way)
    );

    wbp_update #(.CNT_W(CNT_W), .ASSOC(ASSOC)) u_update (
        .op          (op_q),
        .found       (found),
        .cur_learned (learned_q[set_sel][tgt_way]),
        .cur_cnt     (cnt_q[set_sel][tgt_way]),
        .cur_conf    (conf_q[set_sel][tgt_way]),
        .hitpos      (hitpos_q),
        .line_mhp    (mhp_q),
        .ent_we      (ent_we),
        .nxt_learned (nxt_learned),
        .nxt_cnt     (nxt_cnt),
        .nxt_conf    (nxt_conf),
        .rep_found   (rep_found),
        .rep_learned (rep_learned),
        .rep_cnt     (rep_cnt),
        .mhp_wr      (upd_mhp_wr),
        .mhp_new     (upd_mhp)
    );

    // Table storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    v_q[s][w] <= 1'b0;
                end
            end
        end else if (in_exec && ent_we) begin
            v_q[set_sel][tgt_way]       <= 1'b1;
            tag_q[set_sel][tgt_way]     <= tag_sel;
            learned_q[set_sel][tgt_way] <= nxt_learned;
            cnt_q[set_sel][tgt_way]     <= nxt_cnt;
            conf_q[set_sel][tgt_way]    <= nxt_conf;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_found   <= 1'b0;
            rsp_learned <= 1'b0;
            rsp_wblocks <= '0;
            rsp_mhp_wr  <= 1'b0;
            rsp_mhp     <= '0;
        end else begin
            rsp_valid <= in_exec;
            if (in_exec) begin
                rsp_found   <= rep_found;
                rsp_learned <= rep_learned;
                rsp_wblocks <= rep_cnt;
                rsp_mhp_wr  <= upd_mhp_wr;
                rsp_mhp     <= upd_mhp;
            end
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2

    AST_RSP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid); // R2

    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_found) |-> (!rsp_learned && rsp_wblocks == FULL_CNT)); // R8

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_wblocks <= FULL_CNT)); // R7

    AST_HIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op_q == OP_HIT) |=> (rsp_mhp_wr == ($past(hitpos_q) >= $past(mhp_q)))); // R4
endmodule

// File: tb/wbp_table_bench.sv
module wbp_table_bench;
    localparam int CW = 5;
    localparam logic [1:0] LK = 2'd0, AL = 2'd1, HT = 2'd2, EV = 2'd3;

    typedef struct {
        bit    found;
        bit    learned;
        int    cnt;
        bit    wr;
        int    mhp;
        int    due;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = '0;
    logic [14:0] req_pc = '0;
    logic [CW-1:0] req_hitpos = '0;
    logic [CW-1:0] req_mhp = '0;
    logic rsp_valid, rsp_found, rsp_learned, rsp_mhp_wr;
    logic [CW-1:0] rsp_wblocks, rsp_mhp;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wbp_table u_wbp_table (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_pc(req_pc), .req_hitpos(req_hitpos), .req_mhp(req_mhp),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_learned(rsp_learned),
        .rsp_wblocks(rsp_wblocks), .rsp_mhp_wr(rsp_mhp_wr), .rsp_mhp(rsp_mhp)
    );

    task automatic send(input logic [1:0] op, input logic [14:0] pc, input int hp, input int mhp,
                        input bit f, input bit l, input int cnt, input bit wr, input int mnew,
                        input string rq);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_pc = pc;
        req_hitpos = CW'(hp); req_mhp = CW'(mhp);
        e.found = f; e.learned = l; e.cnt = cnt; e.wr = wr; e.mhp = mnew;
        e.due = cyc + 2; e.req = rq;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        vectors++;
        if (req_ready !== 1'b0) begin
            miscompares++;
            $display("FAIL R2 ready after accept: actual %b expected 0", req_ready);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                vectors++;
                if (sb.size() == 0) begin
                    miscompares++;
                    $display("FAIL R2 unexpected response at cycle %0d: actual 1 expected 0", cyc);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (cyc != e.due || rsp_found !== e.found || rsp_learned !== e.learned ||
                        int'(rsp_wblocks) != e.cnt || rsp_mhp_wr !== e.wr || int'(rsp_mhp) != e.mhp) begin
                        miscompares++;
                        $display("FAIL %s: actual cyc=%0d f=%b l=%b cnt=%0d wr=%b mhp=%0d expected cyc=%0d f=%b l=%b cnt=%0d wr=%b mhp=%0d",
                                 e.req, cyc, rsp_found, rsp_learned, rsp_wblocks, rsp_mhp_wr, rsp_mhp,
                                 e.due, e.found, e.learned, e.cnt, e.wr, e.mhp);
                    end
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                vectors++;
                miscompares++;
                $display("FAIL %s missing response at cycle %0d: actual 0 expected 1", sb[0].req, cyc);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        repeat (300000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        vectors++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset: actual ready=%b rsp=%b expected ready=1 rsp=0", req_ready, rsp_valid);
        end
        // R1 empty table, R3 allocate, R6 R7 first evict
        send(LK, 15'h0005, 0, 0, 0, 0, 16, 0, 0, "R1");
        send(AL, 15'h0005, 0, 0, 1, 0, 16, 0, 0, "R3");
        send(LK, 15'h0005, 0, 0, 1, 0, 16, 0, 0, "R3");
        send(EV, 15'h0005, 0, 2, 1, 1, 15, 1, 0, "R6");
        send(HT, 15'h0005, 3, 5, 1, 1, 15, 0, 0, "R4");
        send(HT, 15'h0005, 3, 3, 1, 1, 15, 1, 3, "R4");
        send(HT, 15'h0005, 3, 1, 1, 1, 15, 1, 3, "R5");
        send(LK, 15'h0085, 0, 0, 0, 0, 16, 0, 0, "R10");
        // R7 shrink to floor with empty confidence
        send(AL, 15'h0010, 0, 0, 1, 0, 16, 0, 0, "R3");
        for (int i = 0; i < 16; i++) send(EV, 15'h0010, 0, 0, 1, 1, 15 - i, 1, 0, "R7");
        send(EV, 15'h0010, 0, 0, 1, 1, 0, 1, 0, "R7");
        // R5 growth fills confidence; R7 drains it in three evictions
        send(HT, 15'h0010, 4, 0, 1, 1, 4, 1, 4, "R5");
        for (int i = 0; i < 3; i++) send(EV, 15'h0010, 0, 1, 1, 1, 4, 1, 0, "R7");
        send(EV, 15'h0010, 0, 1, 1, 1, 3, 1, 0, "R7");
        send(EV, 15'h0010, 0, 3, 1, 1, 3, 1, 0, "R7");
        send(HT, 15'h0010, 2, 0, 1, 1, 3, 1, 2, "R5");
        // R9 replacement in set 0x11
        send(AL, 15'h0011, 0, 0, 1, 0, 16, 0, 0, "R9");
        send(AL, 15'h0091, 0, 0, 1, 0, 16, 0, 0, "R9");
        send(AL, 15'h0111, 0, 0, 1, 0, 16, 0, 0, "R9");
        send(AL, 15'h0191, 0, 0, 1, 0, 16, 0, 0, "R9");
        send(LK, 15'h0011, 0, 0, 1, 0, 16, 0, 0, "R9");
        send(EV, 15'h0011, 0, 16, 1, 1, 16, 1, 0, "R6");
        send(AL, 15'h0211, 0, 0, 1, 0, 16, 0, 0, "R9");
        send(LK, 15'h0091, 0, 0, 0, 0, 16, 0, 0, "R9");
        send(LK, 15'h0011, 0, 0, 1, 1, 16, 0, 0, "R9");
        send(LK, 15'h0111, 0, 0, 1, 0, 16, 0, 0, "R9");
        send(LK, 15'h0211, 0, 0, 1, 0, 16, 0, 0, "R10");
        // R3 allocate of a present entry; R8 absent entries
        send(AL, 15'h0005, 0, 0, 1, 1, 15, 0, 0, "R3");
        send(HT, 15'h0300, 2, 0, 0, 0, 16, 1, 2, "R8");
        send(EV, 15'h0300, 0, 0, 0, 0, 16, 1, 0, "R8");
        send(LK, 15'h0300, 0, 0, 0, 0, 16, 0, 0, "R8");
        repeat (4) @(negedge clk);
        vectors++;
        if (sb.size() != 0) begin
            miscompares++;
            $display("FAIL R2 pending responses: actual %0d expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule